// File: doc/BRIEF.md
# Scaler Source-Position Phase Accumulator

This block tracks, for one scaling direction, where each output pixel falls on the source grid. A fixed-point position register is loaded at the start of every line (or every field line for interlaced sources) from one of two programmed start positions, top-field or bottom-field. After that it steps forward by a programmed scale ratio once per output pixel. From the running position it presents the integer source index and a 6-bit phase that picks one of 64 polyphase filter phases. A downstream tap fetcher and filter consume these values.

The ratio is unsigned, with 3 integer bits and 24 fraction bits. Only the upper 19 fraction bits are significant, so the block treats the lowest 5 bits of both the ratio and the start fractions as zero. The start position is given as a separate integer field and a 24-bit fraction. When the integer part would exceed its range, the position clamps and a sticky flag reports the clamp until the next line start.

Top module: `scl_phase_acc`

## Requirements
- R1: After reset, src_index, src_phase, src_frac and sat_flag are all zero.
- R2: A cycle with line_start high loads the position from the top-field start (field_sel=0) or the bottom-field start (field_sel=1). Bits [4:0] of the loaded fraction read as zero, and src_frac shows the loaded fraction from the next cycle.
- R3: Each cycle with pix_step high (and line_start low) adds the ratio to the position. The ratio is 27 bits: bits [26:24] are integer, bits [23:0] are fraction, and bits [4:0] are ignored.
- R4: When line_start and pix_step are high in the same cycle, the reload wins and no step is added.
- R5: src_phase is fraction bits [23:18] rounded to nearest using fraction bit 17. When bits [23:17] are all ones, src_phase is 0 and src_index is the integer part plus one.
- R6: With both strobes low, the position, src_index, src_phase and sat_flag hold their values.
- R7: A step whose sum exceeds the INT_W-bit integer range clamps the position to the maximum integer with fraction 24'hFFFFE0 and sets sat_flag. The flag stays set, and the position stays clamped, until a line_start clears the flag.
- R8: If rounding would carry past the maximum integer index, src_index stays at its maximum and src_phase is 63.
- R9: With a ratio of exactly 1.0, each step advances src_index by one and leaves src_phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Reload position from the selected field start |
| pix_step | input | 1 | Advance position by the ratio |
| field_sel | input | 1 | 0 selects top-field start, 1 selects bottom-field start |
| ratio | input | 27 | Scale ratio, 3.24 unsigned, bits [4:0] ignored |
| init_int_top | input | INT_W | Top-field start, integer part |
| init_frac_top | input | 24 | Top-field start, fraction, bits [4:0] ignored |
| init_int_bot | input | INT_W | Bottom-field start, integer part |
| init_frac_bot | input | 24 | Bottom-field start, fraction, bits [4:0] ignored |
| src_index | output | INT_W | Rounded integer source index |
| src_phase | output | 6 | Rounded filter phase, 0 to 63 |
| src_frac | output | 24 | Raw fraction of the current position |
| sat_flag | output | 1 | Sticky integer-overflow indication |

## Verification
The hardest state to reach is the clamped position. Reaching it takes a run of steps that just crosses the top of the integer range, and that run coexists with the rounding carry at the maximum index. The bench instantiates the block with a narrow 8-bit integer field and steps the largest legal ratio from a known start. It checks the last unclamped position after 31 steps and the clamped one after the 32nd. It then keeps stepping to show that the flag is sticky, and releases the clamp with a reload in the same cycle as a step. The two ignored bit ranges are exposed by feeding ones in the low 5 bits of a start fraction and of the ratio and comparing the raw fraction output.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;
    localparam int FRAC_W      = 24;
    localparam int RATIO_INT_W = 3;
    localparam int RATIO_W     = RATIO_INT_W + FRAC_W;
    localparam int DEAD_LSBS   = 5;
    localparam int PHASE_W     = 6;
    localparam int ROUND_BIT   = FRAC_W - PHASE_W - 1;

    // Clears the insignificant low bits of a fraction-aligned value.
    function automatic logic [FRAC_W-1:0] frac_clean(input logic [FRAC_W-1:0] v);
        return {v[FRAC_W-1:DEAD_LSBS], {DEAD_LSBS{1'b0}}};
    endfunction
endpackage

// File: rtl/scl_init_sel.sv
module scl_init_sel
    import scl_phase_pkg::*;
#(
    parameter int INT_W = 13,
    localparam int POS_W = INT_W + FRAC_W
) (
    input  logic              field_sel,
    input  logic [INT_W-1:0]  int_top,
    input  logic [FRAC_W-1:0] frac_top,
    input  logic [INT_W-1:0]  int_bot,
    input  logic [FRAC_W-1:0] frac_bot,
    output logic [POS_W-1:0]  start_pos
);
    always_comb begin
        if (field_sel) start_pos = {int_bot, frac_clean(frac_bot)};
        else           start_pos = {int_top, frac_clean(frac_top)};
    end
endmodule

// File: rtl/scl_pos_accum.sv
module scl_pos_accum
    import scl_phase_pkg::*;
#(
    parameter int INT_W = 13,
    localparam int POS_W = INT_W + FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               pix_step,
    input  logic [POS_W-1:0]   start_pos,
    input  logic [RATIO_W-1:0] ratio,
    output logic [POS_W-1:0]   pos,
    output logic               sat
);
    localparam logic [POS_W-1:0] SAT_POS = {{INT_W{1'b1}}, frac_clean({FRAC_W{1'b1}})};

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             sat;
    } acc_t;

    acc_t st_d, st_q;
    logic [RATIO_W-1:0] ratio_eff;
    logic [POS_W:0]     sum_d;

    always_comb begin
        ratio_eff = {ratio[RATIO_W-1:FRAC_W], frac_clean(ratio[FRAC_W-1:0])};
        sum_d     = {1'b0, st_q.pos} + {{(POS_W + 1 - RATIO_W){1'b0}}, ratio_eff};
        st_d      = st_q;
        if (line_start) begin
            st_d.pos = start_pos;
            st_d.sat = 1'b0;
        end else if (pix_step) begin
            if (sum_d[POS_W]) begin
                st_d.pos = SAT_POS;
                st_d.sat = 1'b1;
            end else begin
                st_d.pos = sum_d[POS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.pos;
    assign sat = st_q.sat;
endmodule

// File: rtl/scl_phase_round.sv
module scl_phase_round
    import scl_phase_pkg::*;
#(
    parameter int INT_W = 13,
    localparam int POS_W = INT_W + FRAC_W
) (
    input  logic [POS_W-1:0]   pos,
    output logic [INT_W-1:0]   index,
    output logic [PHASE_W-1:0] phase
);
    logic [INT_W-1:0]   int_part;
    logic [PHASE_W-1:0] coarse;
    logic               rnd, carry, at_max;

    always_comb begin
        int_part = pos[POS_W-1:FRAC_W];
        coarse   = pos[FRAC_W-1:FRAC_W-PHASE_W];
        rnd      = pos[ROUND_BIT];
        carry    = &pos[FRAC_W-1:ROUND_BIT];
        at_max   = &int_part;
        if (carry && at_max) begin
            index = int_part;
            phase = {PHASE_W{1'b1}};
        end else begin
            index = int_part + {{(INT_W-1){1'b0}}, carry};
            phase = coarse + {{(PHASE_W-1){1'b0}}, rnd};
        end
    end
endmodule

// File: rtl/scl_phase_acc.sv
module scl_phase_acc
    import scl_phase_pkg::*;
#(
    parameter int INT_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               pix_step,
    input  logic               field_sel,
    input  logic [26:0]        ratio,
    input  logic [INT_W-1:0]   init_int_top,
    input  logic [23:0]        init_frac_top,
    input  logic [INT_W-1:0]   init_int_bot,
    input  logic [23:0]        init_frac_bot,
    output logic [INT_W-1:0]   src_index,
    output logic [5:0]         src_phase,
    output logic [23:0]        src_frac,
    output logic               sat_flag
);
    localparam int POS_W = INT_W + FRAC_W;

    logic [POS_W-1:0] start_pos;
    logic [POS_W-1:0] pos;

    scl_init_sel #(.INT_W(INT_W)) u_sel (
        .field_sel (field_sel),
        .int_top   (init_int_top),
        .frac_top  (init_frac_top),
        .int_bot   (init_int_bot),
        .frac_bot  (init_frac_bot),
        .start_pos (start_pos)
    );

    scl_pos_accum #(.INT_W(INT_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .pix_step   (pix_step),
        .start_pos  (start_pos),
        .ratio      (ratio),
        .pos        (pos),
        .sat        (sat_flag)
    );

    scl_phase_round #(.INT_W(INT_W)) u_rnd (
        .pos   (pos),
        .index (src_index),
        .phase (src_phase)
    );

    assign src_frac = pos[FRAC_W-1:0];
endmodule

// File: rtl/scl_phase_acc_chk.sv
module scl_phase_acc_chk #(
    parameter int INT_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              pix_step,
    input logic              field_sel,
    input logic [26:0]       ratio,
    input logic [23:0]       init_frac_top,
    input logic [23:0]       init_frac_bot,
    input logic [INT_W-1:0]  src_index,
    input logic [5:0]        src_phase,
    input logic [23:0]       src_frac,
    input logic              sat_flag
);
    localparam logic [23:0] KEEP = 24'hFFFFE0;

    // R2: reload shows the selected field's cleaned fraction
    a_r2_reload_frac: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> src_frac == (($past(field_sel) ? $past(init_frac_bot) : $past(init_frac_top)) & KEEP));

    // R2 / R3: low fraction bits never become significant
    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        src_frac[4:0] == 5'd0);

    // R3: fraction advances by the cleaned ratio fraction unless clamped
    a_r3_frac_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_step && !line_start && !sat_flag) |=>
        (sat_flag || src_frac == ($past(src_frac) + ($past(ratio[23:0]) & KEEP))));

    // R6: idle cycles hold everything
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !pix_step) |=>
        ($stable(src_frac) && $stable(src_index) && $stable(src_phase) && $stable(sat_flag)));

    // R7: reload clears the flag
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !sat_flag);

    // R7: flag is sticky until reload
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !line_start) |=> sat_flag);

    // R7 / R8: while clamped, outputs sit at the top value
    a_r8_clamped_out: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |-> (src_frac == KEEP && (&src_index) && src_phase == 6'd63));
endmodule

bind scl_phase_acc scl_phase_acc_chk #(.INT_W(INT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_start    (line_start),
    .pix_step      (pix_step),
    .field_sel     (field_sel),
    .ratio         (ratio),
    .init_frac_top (init_frac_top),
    .init_frac_bot (init_frac_bot),
    .src_index     (src_index),
    .src_phase     (src_phase),
    .src_frac      (src_frac),
    .sat_flag      (sat_flag)
);

// File: tb/sim_scl_phase_acc.sv
module sim_scl_phase_acc;
    localparam int IW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0, pix_step = 1'b0, field_sel = 1'b0;
    logic [26:0] ratio = '0;
    logic [IW-1:0] init_int_top = 8'd3, init_int_bot = 8'd5;
    logic [23:0] init_frac_top = 24'h40001F, init_frac_bot = 24'hC00000;
    logic [IW-1:0] src_index;
    logic [5:0] src_phase;
    logic [23:0] src_frac;
    logic sat_flag;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scl_phase_acc #(.INT_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_step(pix_step),
        .field_sel(field_sel), .ratio(ratio),
        .init_int_top(init_int_top), .init_frac_top(init_frac_top),
        .init_int_bot(init_int_bot), .init_frac_bot(init_frac_bot),
        .src_index(src_index), .src_phase(src_phase), .src_frac(src_frac),
        .sat_flag(sat_flag)
    );

    typedef struct packed {
        logic        fld;
        logic [26:0] rat;
        logic [7:0]  steps;
        logic [7:0]  e_idx;
        logic [5:0]  e_ph;
        logic [23:0] e_frac;
        logic [7:0]  req;
    } vec_t;

    // top start 3.25 (low bits of fraction set), bottom start 5.75
    localparam vec_t TAB [0:6] = '{
        '{1'b0, 27'h1000000, 8'd0, 8'd3, 6'd16, 24'h400000, 8'd2},  // R2 load top
        '{1'b0, 27'h1000000, 8'd4, 8'd7, 6'd16, 24'h400000, 8'd9},  // R9 unit ratio
        '{1'b1, 27'h0800000, 8'd2, 8'd6, 6'd48, 24'hC00000, 8'd3},  // R3 half ratio, bottom
        '{1'b0, 27'h180001F, 8'd2, 8'd6, 6'd16, 24'h400000, 8'd3},  // R3 ratio low bits ignored
        '{1'b0, 27'h0020000, 8'd1, 8'd3, 6'd17, 24'h420000, 8'd5},  // R5 round up
        '{1'b1, 27'h03E0000, 8'd1, 8'd6, 6'd0,  24'hFE0000, 8'd5},  // R5 carry into index
        '{1'b1, 27'h7FFFFE0, 8'd0, 8'd5, 6'd48, 24'hC00000, 8'd2}   // R2 load bottom
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_pos(input string req, input logic [7:0] i, input logic [5:0] p,
                           input logic [23:0] f, input logic s);
        chk(req, "index", 32'(src_index), 32'(i));
        chk(req, "phase", 32'(src_phase), 32'(p));
        chk(req, "frac",  32'(src_frac),  32'(f));
        chk(req, "flag",  32'(sat_flag),  32'(s));
    endtask

    task automatic do_load(input logic fld);
        @(negedge clk);
        field_sel = fld; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic do_steps(input int n);
        if (n > 0) begin
            @(negedge clk);
            pix_step = 1'b1;
            repeat (n) @(negedge clk);
            pix_step = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_pos("R1", 8'd0, 6'd0, 24'h0, 1'b0);
        rst_n = 1'b1;

        for (int k = 0; k < 7; k++) begin
            ratio = TAB[k].rat;
            do_load(TAB[k].fld);
            do_steps(int'(TAB[k].steps));
            chk_pos($sformatf("R%0d", TAB[k].req), TAB[k].e_idx, TAB[k].e_ph, TAB[k].e_frac, 1'b0);
        end

        // R6: idle cycles hold the last position (6.75 from bottom start)
        ratio = 27'h1000000;
        do_load(1'b1);
        do_steps(1);
        repeat (5) @(negedge clk);
        chk_pos("R6", 8'd6, 6'd48, 24'hC00000, 1'b0);

        // R4: reload and step together, reload wins
        @(negedge clk);
        field_sel = 1'b0; line_start = 1'b1; pix_step = 1'b1;
        @(negedge clk);
        line_start = 1'b0; pix_step = 1'b0;
        chk_pos("R4", 8'd3, 6'd16, 24'h400000, 1'b0);

        // R7/R8: clamp with the largest ratio
        ratio = 27'h7FFFFE0;
        do_load(1'b0);
        do_steps(31);
        chk_pos("R7", 8'd251, 6'd16, 24'h3FFC20, 1'b0);
        do_steps(1);
        chk_pos("R8", 8'd255, 6'd63, 24'hFFFFE0, 1'b1);
        do_steps(3);
        chk_pos("R7", 8'd255, 6'd63, 24'hFFFFE0, 1'b1);
        @(negedge clk);
        field_sel = 1'b1; line_start = 1'b1; pix_step = 1'b1;
        @(negedge clk);
        line_start = 1'b0; pix_step = 1'b0;
        chk_pos("R7", 8'd5, 6'd48, 24'hC00000, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule